// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of month, day of week, month and a two-digit year spanning 2000 to 2099. It takes a fast oscillator tick and divides it internally, so one second passes after a fixed number of tick pulses. On every whole second the core advances seconds. A carry then ripples through minutes, hours, date, month and year, and the weekday follows each date change.

Software reaches the core through a byte-wide port. The port uses one index for writing and reading, and the read data follow the index without a clock. A control register at index 0 holds three things: a freeze bit that stops timekeeping, a 12/24-hour display selector, and a self-clearing bit that returns the whole core to its power-on state.

A clock-loss input sets a sticky integrity flag in the top bit of the seconds register. Software clears the flag when it writes a fresh time. A write to any time register also restarts the sub-second divider, so the first advance after the write comes one full second later.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, index 0x03 (seconds) reads 0x80, 0x04 (minutes) 0x00, 0x05 (hours) 0x00, 0x06 (date) 0x01, 0x07 (weekday) 0x00, 0x08 (month) 0x01, 0x09 (year) 0x00, and index 0x00 (control) reads 0x00. Unused indices read 0x00.
- R2: A write stores the byte at the addressed index, and rd_data shows the addressed register combinationally. Unused upper bits read as zero:
  - minutes bit 7
  - hours bits 7:6
  - date bits 7:6
  - weekday bits 7:3
  - month bits 7:5
  - control bits other than 3 and 5
- R3: Seconds advance by one after every PRESCALE sampled osc_tick pulses. The new value is readable in the cycle after the clock edge that samples the last pulse.
- R4: Seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours.
- R5: With control bit 3 clear (24-hour mode), hours run 0x00 to 0x23. The step from 0x23 to 0x00 carries into the date.
- R6: With control bit 3 set (12-hour mode), hours bits 4:0 hold BCD 01 to 12 and hours bit 5 is the PM flag. The order is 12, 01 … 11. PM toggles when 11 advances to 12. Advancing from 11 PM gives 12 AM (0x12) and carries into the date. The hours register is not converted when the mode changes.
- R7: The date rolls to 0x01 after the last day of the month and carries into the month. Months 04, 06, 09 and 11 have 30 days, February has 29 days when the binary year is divisible by 4 and 28 otherwise, and all other months have 31. Month 0x12 rolls to 0x01 and carries into the year, and year 0x99 rolls to 0x00.
- R8: Each date carry also advances the weekday, which wraps from 6 to 0.
- R9: While control bit 5 is set, no time register changes except by a write, and osc_tick pulses are discarded.
- R10: A high clk_fail sets seconds bit 7 at the next edge. The bit stays set until a seconds write with bit 7 at 0 while clk_fail is low. A seconds write with bit 7 at 1 sets the bit.
- R11: A write to any index 0x03 to 0x09 clears the divider and suppresses the advance in that cycle. The next advance needs PRESCALE further pulses.
- R12: Writing control with bit 4 set returns every register and the divider to the R1 state at the next edge. Bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| clk_fail | input | 1 | Oscillator-loss indication |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Register index for write and read |
| wr_data | input | DATA_W | Write byte |
| rd_data | output | DATA_W | Addressed register contents |

## Verification
Several rules are checked by assertions on every cycle:
- the freeze bit holds all time fields steady
- a clock-loss pulse sets the integrity flag, which stays set until a seconds write
- a time write blocks an advance in the following cycle
- seconds wrap to zero
- a software reset restores the power-on state

Calendar arithmetic is shown only by the bench's scenarios, compared against a behavioural model:
- month lengths and the leap-year rule
- the year and weekday wraps
- the 12-hour sequence with its PM toggle and midnight carry
- the exact count of pulses per second

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_SEC  = 3;
   localparam int unsigned IDX_MIN  = 4;
   localparam int unsigned IDX_HOUR = 5;
   localparam int unsigned IDX_DATE = 6;
   localparam int unsigned IDX_WDAY = 7;
   localparam int unsigned IDX_MON  = 8;
   localparam int unsigned IDX_YEAR = 9;

   localparam int unsigned CTL_MODE12 = 3;
   localparam int unsigned CTL_SRST   = 4;
   localparam int unsigned CTL_STOP   = 5;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [5:0] date;
      logic [2:0] wday;
      logic [4:0] mon;
      logic [7:0] year;
   } cal_t;

   localparam cal_t CAL_RST = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                date: 6'h01, wday: 3'h0, mon: 5'h01,
                                year: 8'h00};

   // Two-digit BCD increment without range wrap
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Binary year divisible by four, decided on BCD digits
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [5:0] month_days(input logic [4:0] m, input logic [7:0] y);
      case (m)
         5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcdcal_prescale.sv
module bcdcal_prescale #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic step
);
   localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("bcdcal_prescale: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign step = tick & ~clr;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (clr)              cnt_q <= '0;
         else if (tick)             cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
      assign step = tick & ~clr & (cnt_q == LAST);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q <= LAST)) else $error("divider out of range"); // R3
   end
endmodule

// File: rtl/bcdcal_step.sv
module bcdcal_step
   import bcdcal_pkg::*;
(
   input  cal_t cur,
   input  logic mode12,
   output cal_t nxt
);
   logic c_hr, c_day, c_mon, c_yr;

   always_comb begin
      nxt   = cur;
      c_hr  = 1'b0;
      c_day = 1'b0;
      c_mon = 1'b0;
      c_yr  = 1'b0;

      if (cur.sec == 7'h59) nxt.sec = '0;
      else                  nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));

      if (cur.sec == 7'h59) begin
         if (cur.min == 7'h59) begin
            nxt.min = '0;
            c_hr    = 1'b1;
         end else begin
            nxt.min = 7'(bcd_inc({1'b0, cur.min}));
         end
      end

      if (c_hr) begin
         if (mode12) begin
            if (cur.hour[4:0] == 5'h12) begin
               nxt.hour = {cur.hour[5], 5'h01};
            end else if (cur.hour[4:0] == 5'h11) begin
               nxt.hour = {~cur.hour[5], 5'h12};
               c_day    = cur.hour[5];
            end else begin
               nxt.hour = {cur.hour[5], 5'(bcd_inc({3'b0, cur.hour[4:0]}))};
            end
         end else if (cur.hour == 6'h23) begin
            nxt.hour = '0;
            c_day    = 1'b1;
         end else begin
            nxt.hour = 6'(bcd_inc({2'b0, cur.hour}));
         end
      end

      if (c_day) begin
         nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
         if (cur.date == month_days(cur.mon, cur.year)) begin
            nxt.date = 6'h01;
            c_mon    = 1'b1;
         end else begin
            nxt.date = 6'(bcd_inc({2'b0, cur.date}));
         end
      end

      if (c_mon) begin
         if (cur.mon == 5'h12) begin
            nxt.mon = 5'h01;
            c_yr    = 1'b1;
         end else begin
            nxt.mon = 5'(bcd_inc({3'b0, cur.mon}));
         end
      end

      if (c_yr) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import bcdcal_pkg::*;
#(
   parameter int unsigned PRESCALE = 32768,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              clk_fail,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(IDX_SEC);
   localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(IDX_MIN);
   localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(IDX_HOUR);
   localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(IDX_DATE);
   localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(IDX_WDAY);
   localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(IDX_MON);
   localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(IDX_YEAR);

   if (DATA_W != 8) begin : g_bad_data
      $error("bcd_calendar_clock: DATA_W must be 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("bcd_calendar_clock: ADDR_W must be at least 4");
   end

   cal_t cal_q, cal_nxt;
   logic flag_q, stop_q, mode12_q;
   logic srst, wr_time, adv;

   assign srst    = wr_en && (addr == A_CTRL) && wr_data[CTL_SRST];
   assign wr_time = wr_en && (addr >= A_SEC) && (addr <= A_YEAR);

   bcdcal_prescale #(.PRESCALE(PRESCALE)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_time | stop_q | srst),
      .tick  (osc_tick),
      .step  (adv)
   );

   bcdcal_step u_step (
      .cur    (cal_q),
      .mode12 (mode12_q),
      .nxt    (cal_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q    <= CAL_RST;
         flag_q   <= 1'b1;
         stop_q   <= 1'b0;
         mode12_q <= 1'b0;
      end else if (srst) begin
         cal_q    <= CAL_RST;
         flag_q   <= 1'b1;
         stop_q   <= 1'b0;
         mode12_q <= 1'b0;
      end else begin
         if (adv) cal_q <= cal_nxt;
         if (wr_en) begin
            case (addr)
               A_CTRL: begin
                  stop_q   <= wr_data[CTL_STOP];
                  mode12_q <= wr_data[CTL_MODE12];
               end
               A_SEC:  cal_q.sec  <= wr_data[6:0];
               A_MIN:  cal_q.min  <= wr_data[6:0];
               A_HOUR: cal_q.hour <= wr_data[5:0];
               A_DATE: cal_q.date <= wr_data[5:0];
               A_WDAY: cal_q.wday <= wr_data[2:0];
               A_MON:  cal_q.mon  <= wr_data[4:0];
               A_YEAR: cal_q.year <= wr_data;
               default: ;
            endcase
         end
         if (clk_fail)                       flag_q <= 1'b1;
         else if (wr_en && (addr == A_SEC))  flag_q <= wr_data[7];
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:  rd_data = {2'b0, stop_q, 1'b0, mode12_q, 3'b0};
         A_SEC:   rd_data = {flag_q, cal_q.sec};
         A_MIN:   rd_data = {1'b0, cal_q.min};
         A_HOUR:  rd_data = {2'b0, cal_q.hour};
         A_DATE:  rd_data = {2'b0, cal_q.date};
         A_WDAY:  rd_data = {5'b0, cal_q.wday};
         A_MON:   rd_data = {3'b0, cal_q.mon};
         A_YEAR:  rd_data = cal_q.year;
         default: rd_data = '0;
      endcase
   end

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en) |=> $stable(cal_q)) else $error("time moved while stopped"); // R9
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fail |=> flag_q) else $error("clock loss not flagged"); // R10
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_en && addr == A_SEC)) |=> flag_q) else $error("flag dropped"); // R10
   AST_WRITE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (PRESCALE > 1 && wr_time) |=> !adv) else $error("advance right after time write"); // R11
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cal_q.sec == 7'h59) |=> (cal_q.sec == 7'h00)) else $error("seconds wrap"); // R4
   AST_SRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (cal_q == CAL_RST && flag_q && !stop_q && !mode12_q)) else $error("soft reset"); // R12
endmodule

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;
   localparam int P = 4;

   logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, clk_fail = 1'b0, wr_en = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_ctrl, m_flag, m_sec, m_min, m_hr, m_date, m_wday, m_mon, m_yr, m_pre;

   bcd_calendar_clock #(.PRESCALE(P), .ADDR_W(5), .DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .clk_fail(clk_fail),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
   );

   always #4 clk = ~clk;

   function automatic int b2i(int b); return (b / 16) * 10 + (b % 16); endfunction
   function automatic int i2b(int i); return (i / 10) * 16 + (i % 10); endfunction

   task automatic model_reset();
      m_ctrl = 0; m_flag = 1; m_sec = 0; m_min = 0; m_hr = 0;
      m_date = 1; m_wday = 0; m_mon = 1; m_yr = 0; m_pre = 0;
   endtask

   function automatic int model_read(int a);
      case (a)
         0: return m_ctrl;
         3: return m_flag * 128 + m_sec;
         4: return m_min;
         5: return m_hr;
         6: return m_date;
         7: return m_wday;
         8: return m_mon;
         9: return m_yr;
         default: return 0;
      endcase
   endfunction

   task automatic model_advance();
      int s, mi, h24, h12, pm, d, mo, y, dim;
      s = b2i(m_sec);
      if (s < 59) begin m_sec = i2b(s + 1); return; end
      m_sec = 0;
      mi = b2i(m_min);
      if (mi < 59) begin m_min = i2b(mi + 1); return; end
      m_min = 0;
      if ((m_ctrl & 8) != 0) begin
         h12 = b2i(m_hr % 32); pm = (m_hr / 32) % 2;
         h24 = (h12 % 12) + pm * 12;
      end else h24 = b2i(m_hr);
      h24 = (h24 + 1) % 24;
      if ((m_ctrl & 8) != 0) begin
         h12 = h24 % 12; if (h12 == 0) h12 = 12;
         m_hr = ((h24 >= 12) ? 32 : 0) + i2b(h12);
      end else m_hr = i2b(h24);
      if (h24 != 0) return;
      m_wday = (m_wday + 1) % 7;
      d = b2i(m_date); mo = b2i(m_mon); y = b2i(m_yr);
      if (mo == 2) dim = (y % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
      else dim = 31;
      if (d < dim) begin m_date = i2b(d + 1); return; end
      m_date = 1;
      if (mo < 12) begin m_mon = i2b(mo + 1); return; end
      m_mon = 1;
      m_yr = i2b((y + 1) % 100);
   endtask

   task automatic model_clock();
      bit wt, go;
      int a, d;
      a = int'(addr); d = int'(wr_data);
      wt = wr_en && a >= 3 && a <= 9;
      if (wr_en && a == 0 && (d & 16) != 0) begin model_reset(); return; end
      go = 0;
      if ((m_ctrl & 32) != 0 || wt) m_pre = 0;
      else if (osc_tick) begin
         if (m_pre == P - 1) begin m_pre = 0; go = 1; end
         else m_pre++;
      end
      if (go) model_advance();
      if (wr_en) begin
         case (a)
            0: m_ctrl = d & 8'h28;
            3: begin m_sec = d & 8'h7F; m_flag = d / 128; end
            4: m_min  = d & 8'h7F;
            5: m_hr   = d & 8'h3F;
            6: m_date = d & 8'h3F;
            7: m_wday = d & 8'h07;
            8: m_mon  = d & 8'h1F;
            9: m_yr   = d;
            default: ;
         endcase
      end
      if (clk_fail) m_flag = 1;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_clock();
   end

   // cycle-by-cycle comparison against the reference model (R2 read path)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_tests++;
         if (rd_data !== 8'(model_read(int'(addr)))) begin
            n_fail++;
            $display("FAIL R2 model idx %0d actual %h expected %h", addr, rd_data,
                     8'(model_read(int'(addr))));
         end
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; addr = 5'(a); wr_data = 8'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulses(input int n);
      @(negedge clk); #1;
      osc_tick = 1'b1;
      repeat (n) @(negedge clk);
      #1 osc_tick = 1'b0;
   endtask

   task automatic chk(input int a, input int exp, input string tag);
      @(negedge clk); #1;
      addr = 5'(a);
      @(negedge clk);
      n_tests++;
      if (rd_data !== 8'(exp)) begin
         n_fail++;
         $display("FAIL %s idx %0d actual %h expected %h", tag, a, rd_data, 8'(exp));
      end
   endtask

   task automatic set_time(input int s, input int mi, input int h);
      wr(5, h); wr(4, mi); wr(3, s);
   endtask

   task automatic set_date(input int y, input int mo, input int d, input int wd);
      wr(9, y); wr(8, mo); wr(6, d); wr(7, wd);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk(3, 8'h80, "R1 sec");   chk(4, 8'h00, "R1 min");  chk(5, 8'h00, "R1 hour");
      chk(6, 8'h01, "R1 date");  chk(7, 8'h00, "R1 wday"); chk(8, 8'h01, "R1 mon");
      chk(9, 8'h00, "R1 year");  chk(0, 8'h00, "R1 ctrl"); chk(1, 8'h00, "R1 unused");

      // R2 write/read and masking
      wr(4, 8'h42); chk(4, 8'h42, "R2 min");
      wr(7, 8'hFF); chk(7, 8'h07, "R2 wday mask");
      wr(7, 8'h00);

      // R3 divider, R10 flag cleared by seconds write
      wr(3, 8'h00); chk(3, 8'h00, "R10 flag clear");
      pulses(P - 1); chk(3, 8'h00, "R3 before last pulse");
      pulses(1);     chk(3, 8'h01, "R3 one second");

      // R11 time write restarts the divider
      pulses(P - 1); wr(4, 8'h10);
      pulses(P - 1); chk(3, 8'h01, "R11 held after write");
      pulses(1);     chk(3, 8'h02, "R11 full second");

      // R4 R5 R7 R8 leap February
      set_date(8'h24, 8'h02, 8'h28, 8'h06); set_time(8'h59, 8'h59, 8'h23);
      pulses(P);
      chk(3, 8'h00, "R4 sec wrap");  chk(4, 8'h00, "R4 min wrap");
      chk(5, 8'h00, "R5 midnight");  chk(6, 8'h29, "R7 leap day");
      chk(8, 8'h02, "R7 month kept"); chk(7, 8'h00, "R8 weekday wrap");

      // R7 non-leap February, 30-day month, year wrap
      set_date(8'h23, 8'h02, 8'h28, 8'h02); set_time(8'h59, 8'h59, 8'h23);
      pulses(P); chk(6, 8'h01, "R7 feb28 date"); chk(8, 8'h03, "R7 feb28 month");
      chk(7, 8'h03, "R8 weekday step");
      set_date(8'h25, 8'h04, 8'h30, 8'h01); set_time(8'h59, 8'h59, 8'h23);
      pulses(P); chk(6, 8'h01, "R7 april date"); chk(8, 8'h05, "R7 april month");
      set_date(8'h99, 8'h12, 8'h31, 8'h04); set_time(8'h59, 8'h59, 8'h23);
      pulses(P); chk(9, 8'h00, "R7 year wrap"); chk(8, 8'h01, "R7 december");

      // R6 12-hour mode
      wr(0, 8'h08); chk(0, 8'h08, "R6 mode bit");
      set_date(8'h25, 8'h05, 8'h10, 8'h02);
      set_time(8'h59, 8'h59, 8'h11); pulses(P); chk(5, 8'h32, "R6 noon");
      chk(6, 8'h10, "R6 noon no date");
      set_time(8'h59, 8'h59, 8'h32); pulses(P); chk(5, 8'h21, "R6 one pm");
      set_time(8'h59, 8'h59, 8'h31); pulses(P); chk(5, 8'h12, "R6 midnight");
      chk(6, 8'h11, "R6 date carry");
      set_time(8'h59, 8'h59, 8'h12); pulses(P); chk(5, 8'h01, "R6 one am");

      // R9 stop
      wr(0, 8'h20); set_time(8'h30, 8'h00, 8'h05);
      pulses(3 * P); chk(3, 8'h30, "R9 frozen"); chk(0, 8'h20, "R9 ctrl");
      wr(0, 8'h00); pulses(P); chk(3, 8'h31, "R9 resumed");

      // R10 sticky flag
      @(negedge clk); #1 clk_fail = 1'b1;
      @(negedge clk); #1 clk_fail = 1'b0;
      chk(3, 8'hB1, "R10 flag set");
      pulses(P); chk(3, 8'hB2, "R10 flag sticky");
      wr(3, 8'h85); chk(3, 8'h85, "R10 write sets");
      wr(3, 8'h05); chk(3, 8'h05, "R10 write clears");

      // R12 software reset
      wr(0, 8'h18);
      chk(0, 8'h00, "R12 ctrl"); chk(3, 8'h80, "R12 sec");
      chk(6, 8'h01, "R12 date"); chk(9, 8'h00, "R12 year");

      summary();
      $finish;
   end
endmodule